// File: doc/BRIEF.md
# Parallel Flash Single-Byte Program Sequencer

This block sits on the host side of an asynchronous parallel flash bus and programs one byte per request. A client hands it an address and a data byte over a valid/ready handshake. The sequencer then issues the three unlock writes and the program write on the bus, using separate active-low chip-enable, write-enable and output-enable lines. Each write-enable pulse and each high gap between pulses lasts a configurable number of clock cycles.

After the last write the sequencer reads the programmed address again and again. While the flash is busy it returns the inverse of the written bit 7 at that address. Once bit 7 matches the requested value, the sequencer emits a one-cycle done pulse. If it sees no match within a configured number of reads, it emits a one-cycle error pulse instead. In both cases it returns to idle.

Top module: `fbp_seq`

## Requirements
- R1: Out of reset and whenever idle, `req_ready` is 1, `fl_ce_n`, `fl_we_n` and `fl_oe_n` are 1, `fl_wdata_oe` is 0, and `done_pulse` and `err_pulse` are 0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. From the next cycle `req_ready` stays 0, and changes on the request inputs have no effect, until the cycle that carries the done or error pulse.
- R3: An accepted request produces exactly four bus writes in this order: (address 0x5555, data 0xAA), (0x2AAA, 0x55), (0x5555, 0xA0), then (request address, request byte).
- R4: During every write, `fl_ce_n` is 0, `fl_oe_n` is 1 and `fl_wdata_oe` is 1. `fl_we_n` is low for exactly WP_CYC cycles. Address and data are already driven one cycle before `fl_we_n` falls and do not change until the cycle after it rises.
- R5: Between two consecutive write pulses of one request, `fl_we_n` is high for exactly WH_CYC+1 cycles.
- R6: After the fourth write, each poll is a read of the request address. A read drives `fl_oe_n` low with `fl_ce_n` low for RD_CYC cycles. `fl_rdata[7]` is sampled in the last of those cycles, and `fl_oe_n` goes high for exactly one cycle before the next read.
- R7: When a sampled bit 7 equals bit 7 of the request byte, `done_pulse` is 1 for exactly one cycle, in the cycle after that read. With N mismatching reads before the match, it is high in cycle 4·(1+WP_CYC+WH_CYC)+(N+1)·RD_CYC+N+1, counted from the accept edge.
- R8: If POLL_MAX reads all mismatch, `err_pulse` is 1 for exactly one cycle in cycle 4·(1+WP_CYC+WH_CYC)+POLL_MAX·(RD_CYC+1), and no further reads follow.
- R9: The sequencer judges completion only against the requested bit 7. Asking for a 1 in bit 7 of a cell whose bit 7 already holds 0 therefore ends in the error pulse of R8.
- R10: `done_pulse` and `err_pulse` are never both 1. Whenever `fl_oe_n` is 0, `fl_wdata_oe` is 0 and `fl_we_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Program request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_addr | input | AW | Byte address to program |
| req_data | input | 8 | Byte value to program |
| fl_addr | output | AW | Flash address bus |
| fl_wdata | output | 8 | Flash write data |
| fl_wdata_oe | output | 1 | Enable for the host's data-bus driver |
| fl_rdata | input | 8 | Flash read data |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| done_pulse | output | 1 | One-cycle pulse: program completed |
| err_pulse | output | 1 | One-cycle pulse: completion not seen in time |

## Verification
A step counter or state register that goes wrong shows up on the bus within one write. It appears as a wrong address/data pair at the next rising write-enable, or as a pulse that is one cycle too long or too short. A wrong poll counter or comparison does not show up until the end of the request. There it moves the done or error pulse away from the cycle given by the latency formula, or gives the wrong choice between done and error. The bench therefore checks the exact pulse cycle, the count of reads and the order of writes for every busy length from zero up to beyond the poll limit.

// File: rtl/fbp_pkg.sv
package fbp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_WLOW  = 3'd2,
    ST_WHIGH = 3'd3,
    ST_READ  = 3'd4,
    ST_GAP   = 3'd5
  } fbp_state_e;

  localparam logic [1:0] LAST_STEP = 2'd3;

  // Unlock preamble address for steps 0..2; step 3 uses the client address
  function automatic logic [15:0] unlock_addr(input logic [1:0] step);
    return (step == 2'd1) ? 16'h2AAA : 16'h5555;
  endfunction

  function automatic logic [7:0] unlock_data(input logic [1:0] step);
    case (step)
      2'd0:    return 8'hAA;
      2'd1:    return 8'h55;
      default: return 8'hA0;
    endcase
  endfunction

endpackage

// File: rtl/fbp_cyc_timer.sv
module fbp_cyc_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/fbp_poll_ctr.sv
module fbp_poll_ctr #(
  parameter int LIMIT = 2048
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  output logic at_limit
);

  localparam int PW = (LIMIT > 2) ? $clog2(LIMIT) : 1;

  logic [PW-1:0] cnt_q;
  logic [PW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clear || step;
    cnt_d  = clear ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // High during the last allowed read
  assign at_limit = (cnt_q == PW'(LIMIT - 1));

endmodule

// File: rtl/fbp_seq.sv
module fbp_seq #(
  parameter int AW       = 16,
  parameter int WP_CYC   = 10,
  parameter int WH_CYC   = 10,
  parameter int RD_CYC   = 4,
  parameter int POLL_MAX = 2048
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [7:0]    req_data,
  output logic [AW-1:0] fl_addr,
  output logic [7:0]    fl_wdata,
  output logic          fl_wdata_oe,
  input  logic [7:0]    fl_rdata,
  output logic          fl_ce_n,
  output logic          fl_we_n,
  output logic          fl_oe_n,
  output logic          done_pulse,
  output logic          err_pulse
);
  import fbp_pkg::*;

  localparam int TMAX0 = (WP_CYC > WH_CYC) ? WP_CYC : WH_CYC;
  localparam int TMAX  = (TMAX0 > RD_CYC) ? TMAX0 : RD_CYC;
  localparam int TW    = $clog2(TMAX + 1);

  fbp_state_e    state_q, state_d;
  logic [1:0]    step_q, step_d;
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q;
  logic          lat_en;
  logic          done_q, done_d;
  logic          err_q, err_d;
  logic          tmr_load, tmr_exp;
  logic [TW-1:0] tmr_val;
  logic          poll_clr, poll_inc, poll_last;
  logic          in_write;
  logic          unused_rdata;

  assign unused_rdata = ^fl_rdata[6:0];

  fbp_cyc_timer #(.W(TW)) tmr_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_exp)
  );

  fbp_poll_ctr #(.LIMIT(POLL_MAX)) poll_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (poll_clr),
    .step     (poll_inc),
    .at_limit (poll_last)
  );

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    step_d   = step_q;
    lat_en   = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    poll_clr = 1'b0;
    poll_inc = 1'b0;
    done_d   = 1'b0;
    err_d    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          lat_en   = 1'b1;
          step_d   = 2'd0;
          poll_clr = 1'b1;
          state_d  = ST_SETUP;
        end
      end
      ST_SETUP: begin
        tmr_load = 1'b1;
        tmr_val  = TW'(WP_CYC - 1);
        state_d  = ST_WLOW;
      end
      ST_WLOW: begin
        if (tmr_exp) begin
          tmr_load = 1'b1;
          tmr_val  = TW'(WH_CYC - 1);
          state_d  = ST_WHIGH;
        end
      end
      ST_WHIGH: begin
        if (tmr_exp) begin
          if (step_q == LAST_STEP) begin
            tmr_load = 1'b1;
            tmr_val  = TW'(RD_CYC - 1);
            state_d  = ST_READ;
          end else begin
            step_d  = step_q + 2'd1;
            state_d = ST_SETUP;
          end
        end
      end
      ST_READ: begin
        if (tmr_exp) begin
          if (fl_rdata[7] == data_q[7]) begin
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end else if (poll_last) begin
            err_d   = 1'b1;
            state_d = ST_IDLE;
          end else begin
            poll_inc = 1'b1;
            state_d  = ST_GAP;
          end
        end
      end
      ST_GAP: begin
        tmr_load = 1'b1;
        tmr_val  = TW'(RD_CYC - 1);
        state_d  = ST_READ;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= 2'd0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  // Request capture with explicit enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (lat_en) begin
      addr_q <= req_addr;
      data_q <= req_data;
    end
  end

  // Bus outputs decoded from registered state
  assign in_write    = (state_q == ST_SETUP) || (state_q == ST_WLOW) ||
                       (state_q == ST_WHIGH);
  assign req_ready   = (state_q == ST_IDLE);
  assign fl_ce_n     = (state_q == ST_IDLE);
  assign fl_we_n     = (state_q != ST_WLOW);
  assign fl_oe_n     = (state_q != ST_READ);
  assign fl_wdata_oe = in_write;

  always_comb begin
    if (in_write && (step_q != LAST_STEP)) begin
      fl_addr  = AW'(unlock_addr(step_q));
      fl_wdata = unlock_data(step_q);
    end else begin
      fl_addr  = addr_q;
      fl_wdata = data_q;
    end
  end

  assign done_pulse = done_q;
  assign err_pulse  = err_q;

endmodule

// File: rtl/fbp_seq_chk.sv
module fbp_seq_chk #(
  parameter int AW     = 16,
  parameter int WP_CYC = 10,
  parameter int WH_CYC = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic [AW-1:0] fl_addr,
  input logic [7:0]    fl_wdata,
  input logic          fl_wdata_oe,
  input logic          fl_ce_n,
  input logic          fl_we_n,
  input logic          fl_oe_n,
  input logic          done_pulse,
  input logic          err_pulse
);

  localparam int CW = $clog2(WP_CYC + WH_CYC + 4);

  logic [CW-1:0] low_cnt;
  logic [CW-1:0] high_cnt;
  logic          seen_pulse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt    <= '0;
      high_cnt   <= '0;
      seen_pulse <= 1'b0;
    end else begin
      if (!fl_we_n) low_cnt <= low_cnt + 1'b1;
      else          low_cnt <= '0;
      if (fl_ce_n || !fl_we_n) high_cnt <= '0;
      else                     high_cnt <= high_cnt + 1'b1;
      if (fl_ce_n)       seen_pulse <= 1'b0;
      else if (!fl_we_n) seen_pulse <= 1'b1;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> fl_ce_n && fl_we_n && fl_oe_n && !fl_wdata_oe); // R1

  AST_PULSE_OUT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (done_pulse || err_pulse) |-> req_ready); // R2

  AST_WRITE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_we_n |-> !fl_ce_n && fl_oe_n && fl_wdata_oe); // R4

  AST_SETUP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fl_we_n) |-> $stable(fl_addr) && $stable(fl_wdata)); // R4

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_we_n) |-> $stable(fl_addr) && $stable(fl_wdata)); // R4

  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_we_n) |-> low_cnt == CW'(WP_CYC)); // R4

  AST_HIGH_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(fl_we_n) && seen_pulse) |-> high_cnt == CW'(WH_CYC + 1)); // R5

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse); // R7

  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |=> !err_pulse); // R8

  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_pulse && err_pulse)); // R10

  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_oe_n |-> !fl_wdata_oe && fl_we_n); // R10

endmodule

bind fbp_seq fbp_seq_chk #(
  .AW     (AW),
  .WP_CYC (WP_CYC),
  .WH_CYC (WH_CYC)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready   (req_ready),
  .fl_addr     (fl_addr),
  .fl_wdata    (fl_wdata),
  .fl_wdata_oe (fl_wdata_oe),
  .fl_ce_n     (fl_ce_n),
  .fl_we_n     (fl_we_n),
  .fl_oe_n     (fl_oe_n),
  .done_pulse  (done_pulse),
  .err_pulse   (err_pulse)
);

// File: tb/fbp_seq_tb.sv
module fbp_seq_tb_top;

  localparam int AW  = 16;
  localparam int WP  = 3;
  localparam int WH  = 2;
  localparam int RD  = 2;
  localparam int PM  = 5;
  localparam int WCY = 1 + WP + WH;

  logic          clk;
  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic [AW-1:0] req_addr;
  logic [7:0]    req_data;
  logic [AW-1:0] fl_addr;
  logic [7:0]    fl_wdata;
  logic          fl_wdata_oe;
  logic [7:0]    fl_rdata;
  logic          fl_ce_n, fl_we_n, fl_oe_n;
  logic          done_pulse, err_pulse;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Flash model state
  logic [7:0]    mem [16];
  logic [AW-1:0] exp_addr;
  logic [7:0]    exp_data;
  int            busy_left;
  int            wr_cnt, rd_cnt, low_cnt, high_cnt, gap_cnt;
  logic          prev_we, prev_oe;
  logic [AW-1:0] cap_addr;
  logic [7:0]    cap_data;

  fbp_seq #(
    .AW(AW), .WP_CYC(WP), .WH_CYC(WH), .RD_CYC(RD), .POLL_MAX(PM)
  ) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_wdata_oe(fl_wdata_oe),
    .fl_rdata(fl_rdata),
    .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n),
    .done_pulse(done_pulse), .err_pulse(err_pulse)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  // Read data: inverted bit 7 while busy, stored byte afterwards
  always_comb begin
    if (busy_left > 0) fl_rdata = {~exp_data[7], mem[fl_addr[3:0]][6:0]};
    else               fl_rdata = mem[fl_addr[3:0]];
  end

  // Cycle-level bus monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (!fl_we_n) begin
        chk(!fl_ce_n && fl_oe_n, "R4 ce/oe during write", {fl_ce_n, fl_oe_n}, 2'b01);
        if (prev_we && wr_cnt > 0)
          chk(high_cnt == WH + 1, "R5 write-enable high time", high_cnt, WH + 1);
        low_cnt++;
        cap_addr = fl_addr;
        cap_data = fl_wdata;
      end else if (!prev_we) begin
        chk(low_cnt == WP, "R4 write pulse width", low_cnt, WP);
        case (wr_cnt)
          0: chk(cap_addr == 16'h5555 && cap_data == 8'hAA, "R3 write 1", {cap_addr, cap_data}, 24'h5555AA);
          1: chk(cap_addr == 16'h2AAA && cap_data == 8'h55, "R3 write 2", {cap_addr, cap_data}, 24'h2AAA55);
          2: chk(cap_addr == 16'h5555 && cap_data == 8'hA0, "R3 write 3", {cap_addr, cap_data}, 24'h5555A0);
          3: begin
            chk(cap_addr == exp_addr && cap_data == exp_data, "R3 write 4",
                {cap_addr, cap_data}, {exp_addr, exp_data});
            mem[cap_addr[3:0]] = mem[cap_addr[3:0]] & cap_data;
          end
          default: chk(1'b0, "R3 extra write", wr_cnt + 1, 4);
        endcase
        wr_cnt++;
        low_cnt = 0;
      end
      if (fl_we_n && !fl_ce_n) high_cnt++;
      else                     high_cnt = 0;
      if (!fl_oe_n && prev_oe) begin
        chk(fl_addr == exp_addr && !fl_ce_n, "R6 read address", fl_addr, exp_addr);
        if (rd_cnt > 0) chk(gap_cnt == 1, "R6 gap between reads", gap_cnt, 1);
        rd_cnt++;
      end
      if (fl_oe_n && !prev_oe && busy_left > 0) busy_left--;
      if (fl_oe_n && !fl_ce_n && rd_cnt > 0) gap_cnt++;
      if (!fl_oe_n) gap_cnt = 0;
    end
    prev_we = fl_we_n;
    prev_oe = fl_oe_n;
  end

  task automatic run(input logic [AW-1:0] a, input logic [7:0] d, input int n,
                     input bit keep, input bit exp_err);
    int c;
    int lat;
    int exp_reads;
    if (!keep) mem[a[3:0]] = 8'hFF;
    exp_addr  = a;
    exp_data  = d;
    busy_left = n;
    wr_cnt = 0; rd_cnt = 0; low_cnt = 0; high_cnt = 0; gap_cnt = 0;
    if (exp_err) begin
      lat       = 4 * WCY + PM * (RD + 1);
      exp_reads = PM;
    end else begin
      lat       = 4 * WCY + (n + 1) * RD + n + 1;
      exp_reads = n + 1;
    end
    req_addr  = a;
    req_data  = d;
    req_valid = 1'b1;
    @(negedge clk);
    c = 1;
    chk(req_ready == 1'b0, "R2 ready low after accept", req_ready, 0);
    req_addr = ~a;
    req_data = ~d;
    @(negedge clk); c++;
    @(negedge clk); c++;
    req_valid = 1'b0;
    while (!(done_pulse || err_pulse) && c < 3000) begin
      @(negedge clk); c++;
    end
    if (exp_err) begin
      chk(err_pulse && !done_pulse, "R8 error outcome", {done_pulse, err_pulse}, 2'b01);
      chk(c == lat, "R8 error pulse cycle", c, lat);
    end else begin
      chk(done_pulse && !err_pulse, "R7 done outcome", {done_pulse, err_pulse}, 2'b10);
      chk(c == lat, "R7 done pulse cycle", c, lat);
    end
    chk(wr_cnt == 4, "R3 write count", wr_cnt, 4);
    chk(rd_cnt == exp_reads, "R6 read count", rd_cnt, exp_reads);
    @(negedge clk);
    chk(!done_pulse && !err_pulse, "R7 R8 single-cycle pulse", {done_pulse, err_pulse}, 0);
    chk(req_ready && fl_ce_n && fl_we_n && fl_oe_n, "R1 idle after request",
        {req_ready, fl_ce_n, fl_we_n, fl_oe_n}, 4'hF);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 8'hFF;
    busy_left = 0;
    exp_addr = '0; exp_data = '0;
    wr_cnt = 0; rd_cnt = 0; low_cnt = 0; high_cnt = 0; gap_cnt = 0;
    prev_we = 1'b1; prev_oe = 1'b1;
    cap_addr = '0; cap_data = '0;
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_addr = '0;
    req_data = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(req_ready && fl_ce_n && fl_we_n && fl_oe_n && !fl_wdata_oe && !done_pulse && !err_pulse,
        "R1 reset state", {req_ready, fl_ce_n, fl_we_n, fl_oe_n, fl_wdata_oe, done_pulse, err_pulse},
        7'b1111000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(req_ready && fl_ce_n && !done_pulse, "R1 idle after reset release",
        {req_ready, fl_ce_n, done_pulse}, 3'b110);

    // Sweep busy length across and past the poll limit, both bit-7 values
    for (int n = 0; n <= PM + 1; n++) begin
      for (int b = 0; b < 2; b++) begin
        run(AW'(n * 4099 + b * 771 + 16'h1230), {b[0], 7'(n * 19 + b * 5 + 3)},
            n, 1'b0, n >= PM);
      end
    end

    // R9: cell bit 7 already 0, request asks for 1 -> never matches
    run(16'h4446, 8'h7F, 1, 1'b0, 1'b0);
    run(16'h4446, 8'hFF, 0, 1'b1, 1'b1);
    chk(mem[6] == 8'h7F, "R9 cell keeps programmed zero", mem[6], 8'h7F);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule